// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches a live calendar time, given in BCD by an external timekeeping counter, and raises an alarm when that time agrees with a programmed alarm setting. Five alarm bytes hold the target second, minute, hour, day of month and weekday. The top bit of each byte masks its field, so the field is left out of the comparison. This lets software build alarms such as "every hour at minute 30" or "daily at 07:15:00".

The comparison runs only on a one-second tick strobe. When every unmasked field agrees on a tick, the block sets a sticky alarm flag in a control byte. The flag drives an interrupt output only while a separate enable bit is set. Software sees the block through a simple byte-wide register port: a combinational read and a write strobe that takes effect on the clock edge.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, every alarm byte (addresses 0x0A to 0x0E) reads 0x80 (field masked). The control byte at 0x01 reads 0x00 and `irq` is low.
- R2: The alarm bytes sit at 0x0A seconds, 0x0B minutes, 0x0C hours, 0x0D day of month and 0x0E weekday. Each keeps and reads back the full byte written to it.
- R3: On a cycle with `tick` high, if every unmasked field equals the live time, the alarm flag (bit 4 of the control byte) reads 1 from the next cycle on.
- R4: Bit 7 set in an alarm byte excludes that field, so a mismatch in it does not prevent a match.
- R5: Only the low 7 bits of seconds and minutes, the low 6 bits of hours and day, and the low 3 bits of weekday are compared. Bits 6..3 above those widths in a stored byte have no effect.
- R6: The flag is never set on a cycle without `tick`, even while the time matches.
- R7: With all five fields masked, no tick sets the flag.
- R8: A control-byte write with bit 4 = 0 clears the flag. A write with bit 4 = 1 leaves the flag as it was.
- R9: Bit 1 of the control byte is the interrupt enable. `irq` is high exactly when the flag and the enable are both 1. Clearing the enable drops `irq` but keeps the flag.
- R10: If a clearing write and a matching tick fall in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-second strobe, one cycle wide |
| now_sec | input | 7 | Live seconds, BCD |
| now_min | input | 7 | Live minutes, BCD |
| now_hour | input | 6 | Live hours, BCD |
| now_mday | input | 6 | Live day of month, BCD |
| now_wday | input | 3 | Live weekday, binary 0..6 |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The assertions assume that `tick` is a one-cycle pulse and that the live time fields are stable around it, because they only reason about the cycle that carries the strobe. They also assume register writes are single-cycle strobes sampled on the clock edge. The bench drives every input on the falling edge and holds the time steady before it pulses `tick`. It issues each write as an isolated one-cycle strobe and only combines a write with a tick in the one test aimed at their overlap.

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [6:0]    now_sec,
  input  logic [6:0]    now_min,
  input  logic [5:0]    now_hour,
  input  logic [5:0]    now_mday,
  input  logic [2:0]    now_wday,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTL = AW'(8'h01);
  localparam logic [AW-1:0] A_SEC = AW'(8'h0A);
  localparam logic [AW-1:0] A_MIN = AW'(8'h0B);
  localparam logic [AW-1:0] A_HR  = AW'(8'h0C);
  localparam logic [AW-1:0] A_DAY = AW'(8'h0D);
  localparam logic [AW-1:0] A_WD  = AW'(8'h0E);
  localparam int FLAG_B = 4;
  localparam int IE_B   = 1;
  localparam logic [7:0] MASKED = 8'h80;

  logic [7:0] al_sec, al_min, al_hr, al_day, al_wd;
  logic       flag, ie;
  logic [4:0] msk, hit;
  logic       match, ctl_wr;

  assign msk = {al_wd[7], al_day[7], al_hr[7], al_min[7], al_sec[7]};
  assign hit[0] = msk[0] | (al_sec[6:0] == now_sec);
  assign hit[1] = msk[1] | (al_min[6:0] == now_min);
  assign hit[2] = msk[2] | (al_hr[5:0]  == now_hour);
  assign hit[3] = msk[3] | (al_day[5:0] == now_mday);
  assign hit[4] = msk[4] | (al_wd[2:0]  == now_wday);
  assign match  = (&hit) & ~(&msk);
  assign ctl_wr = reg_wr && (reg_addr == A_CTL);
  assign irq    = flag & ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_sec <= MASKED;
      al_min <= MASKED;
      al_hr  <= MASKED;
      al_day <= MASKED;
      al_wd  <= MASKED;
      flag   <= 1'b0;
      ie     <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_CTL: begin
            ie <= reg_wdata[IE_B];
            if (!reg_wdata[FLAG_B]) flag <= 1'b0;
          end
          A_SEC: al_sec <= reg_wdata;
          A_MIN: al_min <= reg_wdata;
          A_HR:  al_hr  <= reg_wdata;
          A_DAY: al_day <= reg_wdata;
          A_WD:  al_wd  <= reg_wdata;
          default: ;
        endcase
      end
      if (tick && match) flag <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_CTL: begin
        reg_rdata[FLAG_B] = flag;
        reg_rdata[IE_B]   = ie;
      end
      A_SEC: reg_rdata = al_sec;
      A_MIN: reg_rdata = al_min;
      A_HR:  reg_rdata = al_hr;
      A_DAY: reg_rdata = al_day;
      A_WD:  reg_rdata = al_wd;
      default: ;
    endcase
  end

  // R6: a new flag only follows a tick
  a_r6_rise_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(tick));

  // R7: fully masked setting cannot raise the flag
  a_r7_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&msk) && !ctl_wr && !flag) |=> !flag);

  // R8: writing one to the flag bit keeps a set flag
  a_r8_w1_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[FLAG_B] && flag) |=> flag);

  // R8: writing zero without a tick clears the flag
  a_r8_w0_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[FLAG_B] && !tick) |=> !flag);

  // R9: disabling the interrupt silences irq
  a_r9_disable_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !reg_wdata[IE_B]) |=> !irq);

  // R10: a matching tick wins over a concurrent clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && match) |=> flag);
endmodule

// File: tb/cal_alarm_match_test.sv
module cal_alarm_match_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic [6:0] now_sec = 0;
  logic [6:0] now_min = 0;
  logic [5:0] now_hour = 0;
  logic [5:0] now_mday = 0;
  logic [2:0] now_wday = 0;
  logic [4:0] reg_addr = 0;
  logic       reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_run = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cal_alarm_match uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_mday(now_mday), .now_wday(now_wday),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // alarm bytes sec,min,hr,day,wd | time sec,min,hr,day,wd | expected flag
  localparam int NV = 9;
  localparam logic [69:0] VEC [NV] = '{
    {8'h30, 8'h45, 8'h12, 8'h15, 8'h03, 7'h30, 7'h45, 6'h12, 6'h15, 3'd3, 1'b1}, // R3
    {8'h31, 8'h45, 8'h12, 8'h15, 8'h03, 7'h30, 7'h45, 6'h12, 6'h15, 3'd3, 1'b0}, // R3
    {8'hB1, 8'h45, 8'h12, 8'h15, 8'h03, 7'h30, 7'h45, 6'h12, 6'h15, 3'd3, 1'b1}, // R4
    {8'h30, 8'h45, 8'h12, 8'h15, 8'h04, 7'h30, 7'h45, 6'h12, 6'h15, 3'd3, 1'b0}, // R3
    {8'h30, 8'h45, 8'h12, 8'h15, 8'h84, 7'h30, 7'h45, 6'h12, 6'h15, 3'd3, 1'b1}, // R4
    {8'h80, 8'h80, 8'h80, 8'h80, 8'h80, 7'h00, 7'h00, 6'h00, 6'h00, 3'd0, 1'b0}, // R7
    {8'h30, 8'h45, 8'h52, 8'h55, 8'h7B, 7'h30, 7'h45, 6'h12, 6'h15, 3'd3, 1'b1}, // R5
    {8'h99, 8'h07, 8'hA2, 8'hBF, 8'h85, 7'h00, 7'h07, 6'h01, 6'h02, 3'd6, 1'b1}, // R4
    {8'h99, 8'h08, 8'hA2, 8'hBF, 8'h85, 7'h00, 7'h07, 6'h01, 6'h02, 3'd6, 1'b0}  // R4
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic set_time(input logic [6:0] s, input logic [6:0] m,
                          input logic [5:0] h, input logic [5:0] d, input logic [2:0] w);
    @(negedge clk);
    now_sec = s; now_min = m; now_hour = h; now_mday = d; now_wday = w;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rd(5'h0A + 5'(i), d);
      check("R1 alarm byte reset", d, 8'h80);
    end
    rd(5'h01, d);
    check("R1 control reset", d, 8'h00);
    check("R1 irq reset", irq, 0);

    // R2 readback
    for (int i = 0; i < 5; i++) wr(5'h0A + 5'(i), 8'h11 * 8'(i + 3));
    for (int i = 0; i < 5; i++) begin
      rd(5'h0A + 5'(i), d);
      check("R2 readback", d, 8'h11 * (i + 3));
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [69:0] e;
      e = VEC[v];
      wr(5'h0A, e[69:62]); wr(5'h0B, e[61:54]); wr(5'h0C, e[53:46]);
      wr(5'h0D, e[45:38]); wr(5'h0E, e[37:30]);
      wr(5'h01, 8'h02);
      set_time(e[29:23], e[22:16], e[15:10], e[9:4], e[3:1]);
      pulse_tick();
      rd(5'h01, d);
      check("R3/R4/R5/R7 vector flag", d[4], e[0]);
      check("R9 vector irq", irq, e[0]);
    end

    // R6: matching time but no tick
    wr(5'h0A, 8'h20); wr(5'h0B, 8'h10); wr(5'h0C, 8'h08);
    wr(5'h0D, 8'h01); wr(5'h0E, 8'h02);
    wr(5'h01, 8'h02);
    set_time(7'h20, 7'h10, 6'h08, 6'h01, 3'd2);
    repeat (5) @(negedge clk);
    rd(5'h01, d);
    check("R6 no tick no flag", d[4], 0);
    pulse_tick();
    rd(5'h01, d);
    check("R3 tick sets flag", d[4], 1);

    // R8: write 1 keeps the flag, write 0 clears it
    set_time(7'h21, 7'h10, 6'h08, 6'h01, 3'd2);
    wr(5'h01, 8'h12);
    rd(5'h01, d);
    check("R8 write one keeps flag", d[4], 1);
    // R9: disable keeps flag, drops irq
    wr(5'h01, 8'h10);
    rd(5'h01, d);
    check("R9 flag kept when disabled", d[4], 1);
    check("R9 irq low when disabled", irq, 0);
    wr(5'h01, 8'h12);
    check("R9 irq back when enabled", irq, 1);
    wr(5'h01, 8'h02);
    rd(5'h01, d);
    check("R8 write zero clears flag", d[4], 0);
    check("R8 irq follows clear", irq, 0);
    // R8: write 1 does not set a clear flag
    wr(5'h01, 8'h12);
    rd(5'h01, d);
    check("R8 write one no set", d[4], 0);

    // R10: clear and matching tick in the same cycle
    set_time(7'h20, 7'h10, 6'h08, 6'h01, 3'd2);
    @(negedge clk);
    reg_addr = 5'h01; reg_wdata = 8'h02; reg_wr = 1; tick = 1;
    @(negedge clk);
    reg_wr = 0; tick = 0;
    rd(5'h01, d);
    check("R10 set wins over clear", d[4], 1);

    finish_run();
  end
endmodule